// File: doc/BRIEF.md
# Synthesizer Serial Word Loader

This block writes 20-bit control words into the frequency synthesizers of two front-end converter chips, one working at RF and one at IF. Both chips sit on one shared serial data line and one shared serial clock. Each chip has its own active-low latch enable, and that line decides which chip listens. A chip takes in one bit on each rising edge of the serial clock. It commits the collected word when its latch enable rises. The two lowest bits of the word select the internal register in the chip that receives the word: mode, R counter or A/B counter.

The CPU writes one command that holds the word and a destination bit. The block pulls the chosen latch enable low and sends the word MSB first, changing the data while the clock is low. It then returns the clock low and releases the latch enable. A busy flag in the command word stays set until the latch-enable rising edge has taken place, and the block ignores commands that arrive while it is busy. Software builds the words for each channel, such as the fourteen RF channel settings and the single IF setting, and feeds them in one at a time.

Top module: `synth_word_loader`

## Requirements
- R1: After reset and whenever the block is idle, `ser_clk` is low, both `le_rf_n` and `le_if_n` are high and the busy bit reads 0.
- R2: Each accepted command produces exactly 20 rising edges of `ser_clk`. On those edges `ser_dat` carries `cmd_wdata[19:0]` MSB first, so bits 1:0 (the register address) are sent last.
- R3: `ser_dat` changes only while `ser_clk` is low and is stable for the whole high phase.
- R4: Command bit 20 selects the chip: 0 selects RF (`le_rf_n`) and 1 selects IF (`le_if_n`). The selected latch enable is low at every rising edge of `ser_clk` in the transfer. The other latch enable stays high throughout, and the two are never low together.
- R5: The selected latch enable rises no sooner than HALF_CYC clock cycles after the last rising edge of `ser_clk`. `ser_clk` is low when it rises.
- R6: The busy bit `cmd_rdata[21]` reads 1 from the cycle after a command is accepted until after the latch-enable rising edge, and then reads 0.
- R7: A command written while busy is ignored. It does not change the word sent, the chip addressed or the read-back contents.
- R8: `cmd_rdata[20:0]` returns the word and chip-select bit of the last accepted command.
- R9: During a transfer, consecutive rising edges of `ser_clk` are exactly 2*HALF_CYC clock cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_we | input | 1 | Command write strobe, one cycle per command |
| cmd_wdata | input | 21 | Bit 20 selects the chip (0 RF, 1 IF); bits 19:0 hold the word |
| cmd_rdata | output | 22 | Bit 21 is busy; bits 20:0 hold the last accepted command |
| ser_clk | output | 1 | Shared serial clock, idles low |
| ser_dat | output | 1 | Shared serial data, MSB first |
| le_rf_n | output | 1 | Active-low latch enable of the RF chip |
| le_if_n | output | 1 | Active-low latch enable of the IF chip |

## Verification
A corrupted shift register or bit counter shows up as a wrong word or a wrong number of clock edges. This is visible at the latch-enable rising edge of the same transfer, within about 40*HALF_CYC cycles. A state machine that leaves a phase too early or too late changes the spacing of the serial clock edges or the gap before the latch-enable rising edge, and a latch enable held for the wrong chip is visible at the first serial clock rise. A busy flag that clears too early, or that stays clear while a command is accepted, lets a second command overwrite the read-back word or start a second commit. Both effects show at the ports before the next transfer ends.

// File: rtl/swl_pkg.sv
package swl_pkg;
   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_LO   = 3'd1,
      ST_HI   = 3'd2,
      ST_TAIL = 3'd3,
      ST_GAP  = 3'd4
   } swl_state_e;

   typedef enum logic {
      DEST_RF = 1'b0,
      DEST_IF = 1'b1
   } swl_dest_e;
endpackage

// File: rtl/swl_tick.sv
module swl_tick #(
   parameter int HALF_CYC = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic restart,
   output logic tick
);
   generate
      if (HALF_CYC == 1) begin : g_direct
         assign tick = run & ~restart;
      end else begin : g_count
         localparam int CW = $clog2(HALF_CYC);
         localparam logic [CW-1:0] LAST = CW'(HALF_CYC - 1);
         logic [CW-1:0] cnt_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                  cnt_q <= '0;
            else if (restart || !run)    cnt_q <= '0;
            else if (cnt_q == LAST)      cnt_q <= '0;
            else                         cnt_q <= cnt_q + 1'b1;
         end

         assign tick = run & ~restart & (cnt_q == LAST);

         AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
            cnt_q <= LAST); // R9
      end
   endgenerate
endmodule

// File: rtl/swl_cmd_reg.sv
module swl_cmd_reg #(
   parameter int WORD_W = 20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_we,
   input  logic [WORD_W:0]   cmd_wdata,
   input  logic              busy,
   output logic              start,
   output logic [WORD_W-1:0] word_q,
   output logic              sel_q
);
   assign start = cmd_we & ~busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word_q <= '0;
         sel_q  <= 1'b0;
      end else if (start) begin
         word_q <= cmd_wdata[WORD_W-1:0];
         sel_q  <= cmd_wdata[WORD_W];
      end
   end

   AST_HOLD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> ($stable(word_q) && $stable(sel_q))); // R7
endmodule

// File: rtl/swl_shifter.sv
module swl_shifter
   import swl_pkg::*;
#(
   parameter int WORD_W = 20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [WORD_W-1:0] load_word,
   input  logic              load_sel,
   input  logic              tick,
   output logic              busy,
   output logic              ser_clk,
   output logic              ser_dat,
   output logic              le_rf_n,
   output logic              le_if_n
);
   localparam int CNT_W = $clog2(WORD_W);
   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);

   swl_state_e        state_q;
   logic [WORD_W-1:0] sreg_q;
   logic [CNT_W-1:0]  bit_cnt_q;
   logic              sclk_q, le_rf_q, le_if_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         sreg_q    <= '0;
         bit_cnt_q <= '0;
         sclk_q    <= 1'b0;
         le_rf_q   <= 1'b1;
         le_if_q   <= 1'b1;
      end else begin
         unique case (state_q)
            ST_IDLE: if (start) begin
               sreg_q    <= load_word;
               bit_cnt_q <= '0;
               le_rf_q   <= (load_sel != DEST_RF);
               le_if_q   <= (load_sel != DEST_IF);
               state_q   <= ST_LO;
            end
            ST_LO: if (tick) begin
               sclk_q  <= 1'b1;
               state_q <= ST_HI;
            end
            ST_HI: if (tick) begin
               sclk_q <= 1'b0;
               if (bit_cnt_q == LAST_BIT) begin
                  state_q <= ST_TAIL;
               end else begin
                  sreg_q    <= {sreg_q[WORD_W-2:0], 1'b0};
                  bit_cnt_q <= bit_cnt_q + 1'b1;
                  state_q   <= ST_LO;
               end
            end
            ST_TAIL: if (tick) begin
               le_rf_q <= 1'b1;
               le_if_q <= 1'b1;
               sreg_q  <= '0;
               state_q <= ST_GAP;
            end
            ST_GAP: if (tick) begin
               state_q <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign busy    = (state_q != ST_IDLE);
   assign ser_clk = sclk_q;
   assign ser_dat = sreg_q[WORD_W-1];
   assign le_rf_n = le_rf_q;
   assign le_if_n = le_if_q;

   AST_BITCNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      bit_cnt_q <= LAST_BIT); // R2
   AST_DAT_STABLE_HI: assert property (@(posedge clk) disable iff (!rst_n)
      (ser_clk && $past(ser_clk)) |-> $stable(ser_dat)); // R3
   AST_ONE_LE: assert property (@(posedge clk) disable iff (!rst_n)
      (le_rf_n || le_if_n)); // R4
   AST_LE_LOW_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ser_clk) |-> (le_rf_n != le_if_n)); // R4
   AST_LE_RISE_CLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(le_rf_n) || $rose(le_if_n)) |-> (!ser_clk && busy)); // R5
   AST_IDLE_LINES: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!ser_clk && le_rf_n && le_if_n)); // R1
endmodule

// File: rtl/synth_word_loader.sv
module synth_word_loader #(
   parameter int WORD_W   = 20,
   parameter int HALF_CYC = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_we,
   input  logic [WORD_W:0]   cmd_wdata,
   output logic [WORD_W+1:0] cmd_rdata,
   output logic              ser_clk,
   output logic              ser_dat,
   output logic              le_rf_n,
   output logic              le_if_n
);
   localparam int BUSY_BIT = WORD_W + 1;

   generate
      if (WORD_W < 3) begin : g_bad_word
         $error("synth_word_loader: WORD_W must leave room for two address bits and payload");
      end
      if (HALF_CYC < 1) begin : g_bad_half
         $error("synth_word_loader: HALF_CYC must be at least 1");
      end
   endgenerate

   logic              busy, start, tick, sel_q;
   logic [WORD_W-1:0] word_q;

   swl_cmd_reg #(.WORD_W(WORD_W)) u_cmd (
      .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
      .busy(busy), .start(start), .word_q(word_q), .sel_q(sel_q)
   );

   swl_tick #(.HALF_CYC(HALF_CYC)) u_tick (
      .clk(clk), .rst_n(rst_n), .run(busy), .restart(start), .tick(tick)
   );

   swl_shifter #(.WORD_W(WORD_W)) u_shift (
      .clk(clk), .rst_n(rst_n), .start(start),
      .load_word(cmd_wdata[WORD_W-1:0]), .load_sel(cmd_wdata[WORD_W]),
      .tick(tick), .busy(busy), .ser_clk(ser_clk), .ser_dat(ser_dat),
      .le_rf_n(le_rf_n), .le_if_n(le_if_n)
   );

   assign cmd_rdata = {busy, sel_q, word_q};

   AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_we && !cmd_rdata[BUSY_BIT]) |=> cmd_rdata[BUSY_BIT]); // R6
   AST_READBACK_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_we && !cmd_rdata[BUSY_BIT]) |=> (cmd_rdata[WORD_W:0] == $past(cmd_wdata))); // R8
endmodule

// File: tb/sim_synth_word_loader.sv
`timescale 1ns/1ps
module sim_synth_word_loader;
   localparam int W    = 20;
   localparam int HALF = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cmd_we = 1'b0;
   logic [W:0]    cmd_wdata = '0;
   logic [W+1:0]  cmd_rdata;
   logic          ser_clk, ser_dat, le_rf_n, le_if_n;

   always #2.5 clk = ~clk;

   synth_word_loader #(.WORD_W(W), .HALF_CYC(HALF)) u0 (
      .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
      .cmd_rdata(cmd_rdata), .ser_clk(ser_clk), .ser_dat(ser_dat),
      .le_rf_n(le_rf_n), .le_if_n(le_if_n)
   );

   int checks = 0;
   int errors = 0;

   // monitor state, sampled at the falling edge of clk
   int          cyc = 0;
   logic        p_sclk = 1'b0, p_dat = 1'b0, p_rf = 1'b1, p_if = 1'b1;
   logic [31:0] bits;
   int          nrise, rf_cnt, if_cnt, le_bad, dat_bad, per_bad, last_rise, gap;
   logic        sclk_at_le, busy_at_le;
   logic [31:0] le_word;
   logic        exp_sel;

   task automatic mon_clear();
      bits = '0; nrise = 0; rf_cnt = 0; if_cnt = 0; le_bad = 0;
      dat_bad = 0; per_bad = 0; last_rise = 0; gap = 0;
      sclk_at_le = 1'b1; busy_at_le = 1'b0; le_word = '0;
   endtask

   initial mon_clear();

   always @(negedge clk) begin
      cyc++;
      if (ser_clk && !p_sclk) begin
         bits = {bits[30:0], ser_dat};
         if (nrise > 0 && (cyc - last_rise) != 2*HALF) per_bad++;
         nrise++;
         last_rise = cyc;
         if ((exp_sel ? le_if_n : le_rf_n) != 1'b0) le_bad++;
         if ((exp_sel ? le_rf_n : le_if_n) != 1'b1) le_bad++;
      end
      if (ser_clk && p_sclk && ser_dat != p_dat) dat_bad++;
      if (!le_rf_n && !le_if_n) le_bad++;
      if ((le_rf_n && !p_rf) || (le_if_n && !p_if)) begin
         if (le_rf_n && !p_rf) rf_cnt++;
         if (le_if_n && !p_if) if_cnt++;
         gap = cyc - last_rise;
         sclk_at_le = ser_clk;
         busy_at_le = cmd_rdata[W+1];
         le_word = bits;
      end
      p_sclk = ser_clk; p_dat = ser_dat; p_rf = le_rf_n; p_if = le_if_n;
   end

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk); #1;
   endtask

   task automatic issue(input logic sel, input logic [W-1:0] word);
      cmd_wdata = {sel, word};
      cmd_we = 1'b1;
      step();
      cmd_we = 1'b0;
   endtask

   task automatic wait_idle();
      for (int i = 0; i < 1000; i++) begin
         if (!cmd_rdata[W+1]) break;
         step();
      end
      step();
   endtask

   task automatic check_transfer(input logic sel, input logic [W-1:0] word, input string tag);
      chk(nrise == W, {tag, " R2 rise count"}, nrise, W);
      chk(le_word[W-1:0] == word, {tag, " R2 word MSB first"}, le_word, word);
      chk(dat_bad == 0, {tag, " R3 data moved in high phase"}, dat_bad, 0);
      chk(le_bad == 0, {tag, " R4 latch enable selection"}, le_bad, 0);
      chk(rf_cnt == (sel ? 0 : 1), {tag, " R4 RF commits"}, rf_cnt, sel ? 0 : 1);
      chk(if_cnt == (sel ? 1 : 0), {tag, " R4 IF commits"}, if_cnt, sel ? 1 : 0);
      chk(gap >= HALF && !sclk_at_le, {tag, " R5 release gap"}, gap, HALF);
      chk(busy_at_le, {tag, " R6 busy at latch edge"}, busy_at_le, 1);
      chk(!cmd_rdata[W+1], {tag, " R6 busy cleared"}, cmd_rdata[W+1], 0);
      chk(per_bad == 0, {tag, " R9 clock period"}, per_bad, 0);
   endtask

   task automatic t_reset();
      chk(!ser_clk, "R1 ser_clk idle", ser_clk, 0);
      chk(le_rf_n && le_if_n, "R1 latch enables idle", {le_rf_n, le_if_n}, 2'b11);
      chk(!cmd_rdata[W+1], "R1 busy after reset", cmd_rdata[W+1], 0);
   endtask

   task automatic t_write(input logic sel, input logic [W-1:0] word, input string tag);
      mon_clear();
      exp_sel = sel;
      issue(sel, word);
      chk(cmd_rdata[W+1], {tag, " R6 busy after accept"}, cmd_rdata[W+1], 1);
      chk(cmd_rdata[W:0] == {sel, word}, {tag, " R8 readback"}, cmd_rdata[W:0], {sel, word});
      wait_idle();
      check_transfer(sel, word, tag);
      chk(!ser_clk && le_rf_n && le_if_n, {tag, " R1 idle lines"}, {ser_clk, le_rf_n, le_if_n}, 3'b011);
   endtask

   task automatic t_ignore_busy();
      logic [W-1:0] a = 20'h6B2D1;
      logic [W-1:0] b = 20'h1F0E2;
      mon_clear();
      exp_sel = 1'b0;
      issue(1'b0, a);
      repeat (5) step();
      issue(1'b1, b);
      chk(cmd_rdata[W:0] == {1'b0, a}, "R7 readback unchanged", cmd_rdata[W:0], {1'b0, a});
      wait_idle();
      check_transfer(1'b0, a, "busy-write");
      chk(cmd_rdata[W:0] == {1'b0, a}, "R7 readback after transfer", cmd_rdata[W:0], {1'b0, a});
      repeat (10) step();
      chk(!cmd_rdata[W+1] && nrise == W, "R7 no second transfer", nrise, W);
   endtask

   initial begin
      exp_sel = 1'b0;
      repeat (3) step();
      t_reset();
      rst_n = 1'b1;
      step();
      t_reset();
      t_write(1'b0, 20'hA5C31, "rf-mixed");
      t_write(1'b1, 20'h3C0F6, "if-mixed");
      t_write(1'b0, 20'hFFFFF, "rf-ones");
      t_write(1'b1, 20'h00000, "if-zeros");
      t_write(1'b1, 20'hAAAAB, "if-alternate");
      t_ignore_busy();
      t_write(1'b1, 20'h55552, "after-ignore");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule